// File: doc/BRIEF.md
# Set-Associative Instruction Fetch Cache

This block serves a fetch unit with 32-bit instructions. It holds recently used 32-byte lines in a set-associative array, which is backed by a memory read port that returns 64 bits per beat. Each fetch carries a physical address and the matching virtual address. The set index and tag come from the physical address. The virtual address only picks which half of the selected doubleword is returned. A three-bit attribute field at the top of the physical address marks a fetch as uncached. Such a fetch reads one word straight from memory and leaves the cache state alone.

Misses replace the least-recently-used way of the indexed set. The replacement line is filled with four ascending 8-byte beats. A separate maintenance port can invalidate a way by index, invalidate it only when its tag matches, or reload its data. Two line-buffer entries record the line numbers of recent cached fetches. They are loaded in alternation, and every maintenance request clears them.

Top module: `icache`

## Requirements
- R1: After reset every way of every set is invalid, `lb_valid` is 00, `busy` is low and `f_ready` is high, so the first cached fetch to any line misses.
- R2: A fetch whose attribute field `f_pa[PA_W-1:PA_W-3]` equals 5 makes exactly one memory request with `m_word` high at address `f_pa`. It returns `m_rdata[31:0]` and leaves tags, valid bits, LRU order and line buffers unchanged.
- R3: A cached fetch matches the tag `f_pa[PA_W-4:TL]` against all ways of set `f_pa[TL-1:5]` (TL = 5 + log2 SETS). On a hit, `f_rvalid` pulses in the cycle after acceptance, no memory request is made, and the hit way becomes most-recently-used.
- R4: On a miss the least-recently-used way is refilled with four beats at line base + 0, 8, 16 and 24, in that order, with `m_addr` held until `m_valid`. `busy` stays high until the fourth beat. The tag is then written, the way becomes most-recently-used, and `f_rvalid` pulses one cycle later. After reset way i has LRU rank i, so the first miss in a set fills way WAYS-1.
- R5: The returned word comes from doubleword `f_pa[4:3]` of the line. It is bits 63:32 when `f_va[2]` is 1 and bits 31:0 otherwise.
- R6: Each cached fetch, hit or completed miss, loads line-buffer entry `ptr` with `f_pa[PA_W-1:5]`, sets `lb_valid[ptr]` and toggles `ptr`. `ptr` starts at 0, and entry 0 appears on `lb_line0`.
- R7: Maintenance op 0 (`c_op`) clears the valid bit of way `c_va[TL+WW-1:TL]` in set `c_va[TL-1:5]`.
- R8: Maintenance op 4 clears that way's valid bit only when its stored tag equals `c_pa[PA_W-4:TL]`.
- R9: Maintenance op 5 reloads that way's data with four 8-byte beats from the line of `c_pa`, leaving tag and valid unchanged.
- R10: Ops 1, 2, 3, 6 and 7, and any request with `c_sec` high, leave the array untouched. Every accepted maintenance request clears both `lb_valid` bits.
- R11: `c_ready` is low while a fill or uncached read is in progress and while `f_valid` is high, so a fetch wins over a maintenance request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| f_valid | input | 1 | Fetch request |
| f_ready | output | 1 | Fetch accepted this cycle |
| f_pa | input | PA_W | Physical fetch address with attribute field on top |
| f_va | input | VA_W | Virtual fetch address, bit 2 selects the word half |
| f_rvalid | output | 1 | Instruction valid pulse |
| f_rdata | output | 32 | Returned instruction |
| busy | output | 1 | Fill or uncached read in progress |
| c_valid | input | 1 | Maintenance request |
| c_ready | output | 1 | Maintenance accepted this cycle |
| c_op | input | 3 | Maintenance operation code |
| c_sec | input | 1 | Request targets the secondary level (no array effect) |
| c_va | input | VA_W | Selects set and way for maintenance |
| c_pa | input | PA_W | Tag compare and refill address for maintenance |
| m_req | output | 1 | Memory read request |
| m_word | output | 1 | Request is a single 4-byte uncached read |
| m_addr | output | PA_W | Memory read address |
| m_valid | input | 1 | Memory beat returned, completes the request |
| m_rdata | input | 64 | Memory read data |
| lb_valid | output | 2 | Line-buffer entry valid bits |
| lb_line0 | output | PA_W-5 | Line number held by entry 0 |
| lb_line1 | output | PA_W-5 | Line number held by entry 1 |

## Verification
The bench builds the block with 4 sets and 2 ways and a 32-bit address. With so few sets, a handful of line addresses collide in one set, so LRU eviction, re-fetch after eviction and maintenance on a chosen way are reached in a few fetches. A memory responder with a latency that rotates between 0 and 2 cycles exercises address holding across wait cycles. A pseudo-random mix of cached, uncached and maintenance traffic over a few lines also drives conflicts between an active fill and a pending maintenance request.

// File: rtl/icache.sv
module icache #(
  parameter int SETS = 128,
  parameter int WAYS = 2,
  parameter int PA_W = 32,
  parameter int VA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            f_valid,
  output logic            f_ready,
  input  logic [PA_W-1:0] f_pa,
  input  logic [VA_W-1:0] f_va,
  output logic            f_rvalid,
  output logic [31:0]     f_rdata,
  output logic            busy,
  input  logic            c_valid,
  output logic            c_ready,
  input  logic [2:0]      c_op,
  input  logic            c_sec,
  input  logic [VA_W-1:0] c_va,
  input  logic [PA_W-1:0] c_pa,
  output logic            m_req,
  output logic            m_word,
  output logic [PA_W-1:0] m_addr,
  input  logic            m_valid,
  input  logic [63:0]     m_rdata,
  output logic [1:0]      lb_valid,
  output logic [PA_W-6:0] lb_line0,
  output logic [PA_W-6:0] lb_line1
);
  localparam int OFF = 5;
  localparam int IW  = $clog2(SETS);
  localparam int WW  = $clog2(WAYS);
  localparam int TL  = OFF + IW;
  localparam int TW  = PA_W - 3 - TL;
  localparam logic [2:0] UNCACHED = 3'd5;

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_UNC, S_CFILL} st_t;
  st_t st;

  logic [TW-1:0]   tag_q [SETS][WAYS];
  logic [WAYS-1:0] vld_q [SETS];
  logic [WW-1:0]   age_q [SETS][WAYS];
  logic [63:0]     dat_q [SETS][WAYS][4];

  logic [1:0]      beat, r_sel;
  logic [IW-1:0]   r_idx;
  logic [WW-1:0]   r_way;
  logic [PA_W-1:0] r_pa;
  logic            r_hi;
  logic [63:0]     sel_q;
  logic            lb_ptr;
  logic [PA_W-6:0] lb_q [2];

  wire [IW-1:0] f_idx = f_pa[TL-1:OFF];
  wire [TW-1:0] f_tag = f_pa[PA_W-4:TL];
  wire          f_unc = f_pa[PA_W-1:PA_W-3] == UNCACHED;
  wire [IW-1:0] c_idx = c_va[TL-1:OFF];
  wire [WW-1:0] c_way = c_va[TL+WW-1:TL];
  wire [TW-1:0] c_tag = c_pa[PA_W-4:TL];
  wire [TW-1:0] r_tag = r_pa[PA_W-4:TL];
  wire unused_bits = ^{f_va[VA_W-1:3], f_va[1:0], c_va[VA_W-1:TL+WW], c_va[OFF-1:0]};

  logic [WAYS-1:0] hitv;
  logic [WW-1:0]   hit_w, vic_w;
  always_comb begin
    hit_w = '0;
    vic_w = '0;
    for (int w = 0; w < WAYS; w++) begin
      hitv[w] = vld_q[f_idx][w] && (tag_q[f_idx][w] == f_tag);
      if (hitv[w]) hit_w = WW'(w);
      if (age_q[f_idx][w] == WW'(WAYS - 1)) vic_w = WW'(w);
    end
  end

  assign f_ready = st == S_IDLE;
  assign c_ready = st == S_IDLE && !f_valid;
  assign busy    = st != S_IDLE;
  assign m_req   = busy;
  assign m_word  = st == S_UNC;
  assign m_addr  = m_word ? r_pa : {r_pa[PA_W-1:OFF], beat, 3'b000};

  wire        f_acc     = f_valid && f_ready;
  wire        c_acc     = c_valid && c_ready;
  wire        beat_ok   = m_req && m_valid;
  wire        done      = beat_ok && (m_word || beat == 2'd3);
  wire        f_hit     = f_acc && !f_unc && (|hitv);
  wire        fill_done = done && st == S_FILL;
  wire        touch     = f_hit || fill_done;
  wire [IW-1:0] t_idx   = f_hit ? f_idx : r_idx;
  wire [WW-1:0] t_way   = f_hit ? hit_w : r_way;
  wire [63:0] hit_dw    = dat_q[f_idx][hit_w][f_pa[4:3]];
  wire [63:0] fill_dw   = (r_sel == 2'd3) ? m_rdata : sel_q;
  wire        inv_hit   = c_acc && !c_sec &&
                          (c_op == 3'd0 || (c_op == 3'd4 && tag_q[c_idx][c_way] == c_tag));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      beat     <= '0;
      r_sel    <= '0;
      r_idx    <= '0;
      r_way    <= '0;
      r_pa     <= '0;
      r_hi     <= 1'b0;
      sel_q    <= '0;
      f_rvalid <= 1'b0;
      f_rdata  <= '0;
    end else begin
      f_rvalid <= f_hit || (done && st != S_CFILL);
      if (f_hit) f_rdata <= f_va[2] ? hit_dw[63:32] : hit_dw[31:0];
      case (st)
        S_IDLE: begin
          if (f_acc && (f_unc || !(|hitv))) begin
            st    <= f_unc ? S_UNC : S_FILL;
            beat  <= '0;
            r_pa  <= f_pa;
            r_idx <= f_idx;
            r_way <= vic_w;
            r_sel <= f_pa[4:3];
            r_hi  <= f_va[2];
          end else if (c_acc && !c_sec && c_op == 3'd5) begin
            st    <= S_CFILL;
            beat  <= '0;
            r_pa  <= c_pa;
            r_idx <= c_idx;
            r_way <= c_way;
          end
        end
        default: begin
          if (beat_ok) begin
            if (beat == r_sel) sel_q <= m_rdata;
            beat <= beat + 2'd1;
            if (done) begin
              st <= S_IDLE;
              if (m_word) f_rdata <= m_rdata[31:0];
              else if (st == S_FILL) f_rdata <= r_hi ? fill_dw[63:32] : fill_dw[31:0];
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WW'(w);
      end
    end else begin
      if (touch) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WW'(w) == t_way) age_q[t_idx][w] <= '0;
          else if (age_q[t_idx][w] < age_q[t_idx][t_way]) age_q[t_idx][w] <= age_q[t_idx][w] + 1'b1;
        end
      end
      if (fill_done) vld_q[r_idx][r_way] <= 1'b1;
      if (inv_hit) vld_q[c_idx][c_way] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_done) tag_q[r_idx][r_way] <= r_tag;
    if (beat_ok && !m_word) dat_q[r_idx][r_way][beat] <= m_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lb_valid <= 2'b00;
      lb_ptr   <= 1'b0;
      lb_q[0]  <= '0;
      lb_q[1]  <= '0;
    end else if (c_acc) begin
      lb_valid <= 2'b00;
    end else if (touch) begin
      lb_q[lb_ptr]     <= f_hit ? f_pa[PA_W-1:OFF] : r_pa[PA_W-1:OFF];
      lb_valid[lb_ptr] <= 1'b1;
      lb_ptr           <= !lb_ptr;
    end
  end

  assign lb_line0 = lb_q[0];
  assign lb_line1 = lb_q[1];

  AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hitv)); // R3
  AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    f_hit |=> !m_req && f_rvalid); // R3
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    m_req && !m_valid |=> m_req && $stable(m_addr)); // R4
  AST_UNC_NO_LB: assert property (@(posedge clk) disable iff (!rst_n)
    f_acc && f_unc |=> $stable(lb_valid) && $stable(lb_ptr)); // R2
  AST_LB_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    touch |=> lb_ptr != $past(lb_ptr)); // R6
  AST_LB_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    c_acc |=> lb_valid == 2'b00); // R10
endmodule

// File: tb/sim_icache.sv
module sim_icache;
  localparam int SETS = 4;
  localparam int WAYS = 2;
  localparam int PA_W = 32;
  localparam int VA_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic            f_valid, f_ready, f_rvalid, busy;
  logic [PA_W-1:0] f_pa;
  logic [VA_W-1:0] f_va;
  logic [31:0]     f_rdata;
  logic            c_valid, c_ready, c_sec;
  logic [2:0]      c_op;
  logic [VA_W-1:0] c_va;
  logic [PA_W-1:0] c_pa;
  logic            m_req, m_word, m_valid;
  logic [PA_W-1:0] m_addr;
  logic [63:0]     m_rdata;
  logic [1:0]      lb_valid;
  logic [PA_W-6:0] lb_line0, lb_line1;

  icache #(.SETS(SETS), .WAYS(WAYS), .PA_W(PA_W), .VA_W(VA_W)) u0 (.*);

  int checks = 0;
  int fails = 0;
  int beats_total = 0;
  logic [31:0] gen = 32'h0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] memf(input logic [31:0] a);
    return {a ^ gen, ~a ^ gen};
  endfunction

  // memory responder, latency rotates 0..2
  int lat = 0, wcnt = 0;
  always @(negedge clk) begin
    if (m_req) begin
      if (wcnt >= lat) begin
        m_valid = 1'b1;
        m_rdata = memf(m_addr);
        beats_total++;
        wcnt = 0;
        lat = (lat + 1) % 3;
      end else begin
        m_valid = 1'b0;
        wcnt++;
      end
    end else begin
      m_valid = 1'b0;
      wcnt = 0;
    end
  end

  // behavioural reference model
  int mst = 0, mbeat = 0, midx = 0, mway = 0, msel = 0, mptr = 0;
  logic [31:0] mpa = '0;
  bit mhi = 0;
  logic [21:0] mtag [SETS][WAYS];
  bit          mv   [SETS][WAYS];
  int          mage [SETS][WAYS];
  logic [63:0] mdat [SETS][WAYS][4];
  bit          mlbv [2];
  logic [26:0] mlbl [2];
  bit erv = 0;
  logic [31:0] erd = '0;
  string erq = "R3";

  function automatic void mtouch(input int i, input int w);
    int a = mage[i][w];
    for (int k = 0; k < WAYS; k++) begin
      if (k == w) mage[i][k] = 0;
      else if (mage[i][k] < a) mage[i][k] = mage[i][k] + 1;
    end
  endfunction

  function automatic void mlb(input logic [31:0] pa);
    mlbl[mptr] = pa[31:5];
    mlbv[mptr] = 1;
    mptr = 1 - mptr;
  endfunction

  function automatic int where(input logic [31:0] pa);
    int r = -1;
    for (int w = 0; w < WAYS; w++)
      if (mv[pa[6:5]][w] && mtag[pa[6:5]][w] == pa[28:7]) r = w;
    return r;
  endfunction

  always begin
    @(negedge clk);
    #5;
    if (rst_n) begin
      logic [63:0] dw;
      logic [31:0] ea;
      int i, hw, vw;
      chk(f_rvalid == erv, erq, f_rvalid, erv);
      if (erv) chk(f_rdata == erd, (erq == "R3") ? "R5" : erq, f_rdata, erd);
      chk(busy == (mst != 0), "R4", busy, mst != 0);
      chk(c_ready == (mst == 0 && !f_valid), "R11", c_ready, mst == 0 && !f_valid);
      chk(lb_valid == {mlbv[1], mlbv[0]}, "R6", lb_valid, {mlbv[1], mlbv[0]});
      if (mlbv[0]) chk(lb_line0 == mlbl[0], "R6", lb_line0, mlbl[0]);
      if (mlbv[1]) chk(lb_line1 == mlbl[1], "R6", lb_line1, mlbl[1]);
      chk(m_req == (mst != 0), "R4", m_req, mst != 0);
      if (mst != 0) begin
        ea = (mst == 2) ? mpa : {mpa[31:5], 2'(mbeat), 3'b000};
        chk(m_addr == ea, (mst == 2) ? "R2" : ((mst == 3) ? "R9" : "R4"), m_addr, ea);
        chk(m_word == (mst == 2), "R2", m_word, mst == 2);
      end
      erv = 0;
      if (mst == 0) begin
        if (f_valid) begin
          i = f_pa[6:5];
          if (f_pa[31:29] == 3'd5) begin
            mst = 2;
            mpa = f_pa;
          end else begin
            hw = where(f_pa);
            if (hw >= 0) begin
              mtouch(i, hw);
              mlb(f_pa);
              dw = mdat[i][hw][f_pa[4:3]];
              erv = 1;
              erd = f_va[2] ? dw[63:32] : dw[31:0];
              erq = "R3";
            end else begin
              vw = 0;
              for (int w = 0; w < WAYS; w++) if (mage[i][w] == WAYS - 1) vw = w;
              mst = 1; mbeat = 0; midx = i; mway = vw;
              mpa = f_pa; msel = f_pa[4:3]; mhi = f_va[2];
            end
          end
        end else if (c_valid) begin
          mlbv[0] = 0;
          mlbv[1] = 0;
          if (!c_sec) begin
            i = c_va[6:5];
            hw = c_va[7];
            case (c_op)
              3'd0: mv[i][hw] = 0;
              3'd4: if (mtag[i][hw] == c_pa[28:7]) mv[i][hw] = 0;
              3'd5: begin mst = 3; mbeat = 0; midx = i; mway = hw; mpa = c_pa; end
              default: ;
            endcase
          end
        end
      end else if (m_valid) begin
        if (mst == 2) begin
          dw = memf(mpa);
          erv = 1; erd = dw[31:0]; erq = "R2";
          mst = 0;
        end else begin
          mdat[midx][mway][mbeat] = memf({mpa[31:5], 2'(mbeat), 3'b000});
          mbeat++;
          if (mbeat == 4) begin
            if (mst == 1) begin
              mtag[midx][mway] = mpa[28:7];
              mv[midx][mway] = 1;
              mtouch(midx, mway);
              mlb(mpa);
              dw = mdat[midx][mway][msel];
              erv = 1; erd = mhi ? dw[63:32] : dw[31:0]; erq = "R4";
            end
            mst = 0;
          end
        end
      end
    end
  end

  task automatic fetch(input logic [31:0] pa, input logic [31:0] va, output int nb);
    int b0;
    @(negedge clk);
    f_valid = 1'b1; f_pa = pa; f_va = va;
    #5;
    while (!f_ready) begin @(negedge clk); #5; end
    b0 = beats_total;
    @(negedge clk);
    f_valid = 1'b0;
    while (!f_rvalid) @(negedge clk);
    nb = beats_total - b0;
  endtask

  task automatic maint(input logic [2:0] op, input bit sec, input logic [31:0] va, input logic [31:0] pa);
    @(negedge clk);
    c_valid = 1'b1; c_op = op; c_sec = sec; c_va = va; c_pa = pa;
    #5;
    while (!c_ready) begin @(negedge clk); #5; end
    @(negedge clk);
    c_valid = 1'b0;
    while (busy) @(negedge clk);
  endtask

  function automatic logic [31:0] cva(input logic [31:0] pa, input int w);
    return {pa[31:8], w[0], pa[6:0]};
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R11: actual run still busy expected completion");
    summary();
    $finish;
  end

  localparam logic [31:0] LA = 32'h080;
  localparam logic [31:0] LB = 32'h100;
  localparam logic [31:0] LC = 32'h180;
  localparam logic [31:0] LD = 32'h0A0;

  initial begin
    int nb, w;
    logic [31:0] r, pa;
    f_valid = 0; f_pa = '0; f_va = '0;
    c_valid = 0; c_op = '0; c_sec = 0; c_va = '0; c_pa = '0;
    m_valid = 0; m_rdata = '0;
    for (int s = 0; s < SETS; s++)
      for (int k = 0; k < WAYS; k++) begin
        mv[s][k] = 0; mage[s][k] = k; mtag[s][k] = '0;
        for (int b = 0; b < 4; b++) mdat[s][k][b] = '0;
      end
    mlbv[0] = 0; mlbv[1] = 0; mlbl[0] = '0; mlbl[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #5;
    chk(f_ready == 1'b1, "R1", f_ready, 1);
    chk(busy == 1'b0, "R1", busy, 0);
    chk(lb_valid == 2'b00, "R1", lb_valid, 0);

    fetch(LA + 12, 32'h4, nb);  chk(nb == 4, "R1", nb, 4);
    chk(where(LA) == WAYS - 1, "R4", where(LA), WAYS - 1);
    fetch(LA + 16, 32'h0, nb);  chk(nb == 0, "R3", nb, 0);
    fetch(LB, 32'h4, nb);       chk(nb == 4, "R4", nb, 4);
    fetch(LA + 4, 32'h0, nb);   chk(nb == 0, "R3", nb, 0);
    fetch(LC + 24, 32'h4, nb);  chk(nb == 4, "R4", nb, 4);
    fetch(LA, 32'h0, nb);       chk(nb == 0, "R4", nb, 0);
    fetch(LB + 8, 32'h0, nb);   chk(nb == 4, "R4", nb, 4);

    fetch(32'hA000_0000 | LA | 32'h8, 32'h0, nb); chk(nb == 1, "R2", nb, 1);
    fetch(LA + 28, 32'h4, nb);  chk(nb == 0, "R2", nb, 0);

    w = where(LA);
    maint(3'd0, 0, cva(LA, w), 32'h0);
    chk(lb_valid == 2'b00, "R10", lb_valid, 0);
    fetch(LA, 32'h0, nb);       chk(nb == 4, "R7", nb, 4);

    w = where(LA);
    maint(3'd4, 0, cva(LA, w), LC);
    fetch(LA, 32'h0, nb);       chk(nb == 0, "R8", nb, 0);
    maint(3'd4, 0, cva(LA, w), LA);
    fetch(LA, 32'h0, nb);       chk(nb == 4, "R8", nb, 4);

    gen = 32'h1234_5678;
    w = where(LA);
    maint(3'd5, 0, cva(LA, w), LA);
    fetch(LA + 8, 32'h4, nb);   chk(nb == 0, "R9", nb, 0);

    w = where(LA);
    for (int op = 1; op < 8; op++)
      if (op != 4 && op != 5) begin
        maint(3'(op), 0, cva(LA, w), LA);
        chk(lb_valid == 2'b00, "R10", lb_valid, 0);
      end
    maint(3'd0, 1, cva(LA, w), LA);
    maint(3'd4, 1, cva(LA, w), LA);
    fetch(LA, 32'h4, nb);       chk(nb == 0, "R10", nb, 0);

    fork
      fetch(LD + 4, 32'h4, nb);
      begin @(negedge clk); @(negedge clk); maint(3'd0, 0, cva(LD, 0), 32'h0); end
    join
    fork
      fetch(LA + 20, 32'h0, nb);
      maint(3'd1, 0, 32'h0, 32'h0);
    join
    chk(nb == 0, "R11", nb, 0);

    r = 32'hACE1_2345;
    for (int k = 0; k < 300; k++) begin
      r ^= r << 13; r ^= r >> 17; r ^= r << 5;
      pa = ((r[3:0] == 4'd0) ? 32'hA000_0000 : 32'h0) |
           (32'(r[6:4]) << 7) | (32'(r[8:7]) << 5) | (32'(r[11:9]) << 2);
      if (r[15:13] == 3'd0) begin
        if (r[18:16] == 3'd5) gen = gen + 32'h0101_0101;
        maint(r[18:16], r[19], cva(pa, int'(r[20])), pa);
      end else fetch(pa, {29'b0, r[12], 2'b00}, nb);
    end

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule